// File: doc/BRIEF.md
# Exponent-Mantissa Elapsed Cycle Counter

This block measures how many active cycles have passed since the last recorded control transfer. It turns that count into a compact 16-bit code: a 12-bit mantissa and an exponent of up to 4 bits. It also keeps a flag that says whether the count is trustworthy. The record keeper samples both values in the cycle it raises the capture strobe. The counter then starts again from zero, and the flag is set for the next interval.

A buffer-clear command and any write to the transfer-record control register both restart the count. Only the clear command drops the flag. An input that marks cycles as not counted also drops the flag, so the next record is marked unreliable.

The parameter `EXP_BITS` (0 to 4) sets how many exponent bits exist. The internal counter is exactly wide enough for the largest value the chosen exponent can express, and it stops at that value. Every input is a plain single-cycle strobe. The block has no handshake and cannot apply back-pressure: the capturing logic must take the code in the same cycle it pulses `capture_i`.

Top module: `xfer_cycle_encoder`

## Requirements
- R1: The field is laid out as bits [11:0] for the mantissa and bits [15:12] for the exponent. After reset the field is 0 and `ccv_o` is 0.
- R2: The count rises by one on each edge where `tick_i` is high and no restart input is high. With `tick_i` low, the field holds its value.
- R3: For counts below 4096, the exponent is 0 and the mantissa equals the count.
- R4: For counts of 4096 and above, where the most significant one bit is at index p, the exponent is p-11 and the mantissa is count bits [p-1:p-12].
- R5: Exponent bits at index 12+`EXP_BITS` and above are always 0.
- R6: The count stops at 2^(12+2^`EXP_BITS`-1)-1. At that count the field shows the largest exponent and an all-ones mantissa.
- R7: While `capture_i` is high, the field shows the count gathered so far. In the next cycle the field is 0 (a tick in the capture cycle is dropped) and `ccv_o` is 1.
- R8: `clear_i` zeroes the count and `ccv_o` in the next cycle. This takes priority over a capture in the same cycle.
- R9: `ctl_wr_i` zeroes the count in the next cycle and leaves `ccv_o` unchanged.
- R10: `uncounted_i` zeroes `ccv_o` in the next cycle. This takes priority over a capture in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Count enable, one per active cycle |
| capture_i | input | 1 | A transfer record is being written this cycle |
| clear_i | input | 1 | Buffer-clear command |
| ctl_wr_i | input | 1 | Write to the record control register |
| uncounted_i | input | 1 | Cycles are passing without being counted |
| cc_field_o | output | 16 | Encoded count {exponent, mantissa} |
| ccv_o | output | 1 | Count-valid flag |

## Verification
The hardest state to reach is saturation. It takes tens of thousands of uninterrupted ticks, so the bench builds the block with a two-bit exponent to keep the ceiling at 32767. It then ticks past that ceiling with no restart and checks the all-ones code. On the way up, the bench samples counts just inside each exponent band so that every mantissa window is seen. It also pairs capture with clear and with `uncounted_i` in the same cycle to confirm which input wins.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
  localparam int MANT_W  = 12;
  localparam int FIELD_W = 16;

  function automatic int exp_max(input int eb);
    return (1 << eb) - 1;
  endfunction

  function automatic int cnt_width(input int eb);
    return MANT_W + exp_max(eb);
  endfunction
endpackage

// File: rtl/ecc_counter.sv
module ecc_counter #(
  parameter int CNT_W = 27
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             restart,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     cnt <= '0;
    else if (restart)               cnt <= '0;
    else if (tick && cnt != TOP)    cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ecc_encoder.sv
module ecc_encoder #(
  parameter int EXP_BITS = 4,
  parameter int CNT_W    = 27
) (
  input  logic [CNT_W-1:0] cnt,
  output logic [15:0]      field
);
  generate
    if (EXP_BITS == 0) begin : g_noexp
      assign field = {4'b0000, cnt[11:0]};
    end else begin : g_exp
      logic [EXP_BITS-1:0] expv;
      logic [4:0]          sh;
      logic [CNT_W-1:0]    shifted;
      logic [11:0]         mant;
      always_comb begin
        expv = '0;
        for (int i = 12; i < CNT_W; i++)
          if (cnt[i]) expv = EXP_BITS'(i - 11);
        sh      = 5'(expv) - 5'd1;
        shifted = cnt >> sh;
        mant    = (expv == '0) ? cnt[11:0] : shifted[11:0];
      end
      assign field = {4'(expv), mant};
    end
  endgenerate
endmodule

// File: rtl/ecc_valid.sv
module ecc_valid (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  input  logic drop,
  input  logic arm,
  output logic vld
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     vld <= 1'b0;
    else if (clear) vld <= 1'b0;
    else if (drop)  vld <= 1'b0;
    else if (arm)   vld <= 1'b1;
  end
endmodule

// File: rtl/xfer_cycle_encoder.sv
module xfer_cycle_encoder
  import ecc_pkg::*;
#(
  parameter int EXP_BITS = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick_i,
  input  logic        capture_i,
  input  logic        clear_i,
  input  logic        ctl_wr_i,
  input  logic        uncounted_i,
  output logic [15:0] cc_field_o,
  output logic        ccv_o
);
  localparam int CNT_W = cnt_width(EXP_BITS);

  logic [CNT_W-1:0] cnt;
  logic             restart;

  assign restart = clear_i | ctl_wr_i | capture_i;

  ecc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick_i), .restart(restart), .cnt(cnt)
  );

  ecc_encoder #(.EXP_BITS(EXP_BITS), .CNT_W(CNT_W)) u_enc (
    .cnt(cnt), .field(cc_field_o)
  );

  ecc_valid u_vld (
    .clk(clk), .rst_n(rst_n), .clear(clear_i), .drop(uncounted_i),
    .arm(capture_i), .vld(ccv_o)
  );
endmodule

// File: rtl/xfer_cycle_encoder_chk.sv
module xfer_cycle_encoder_chk #(
  parameter int EXP_BITS = 4
) (
  input logic        clk,
  input logic        rst_n,
  input logic        tick_i,
  input logic        capture_i,
  input logic        clear_i,
  input logic        ctl_wr_i,
  input logic        uncounted_i,
  input logic [15:0] cc_field_o,
  input logic        ccv_o
);
  assert_restart_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_i || clear_i || ctl_wr_i) |=> cc_field_o == 16'd0);

  assert_clear_invalid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> !ccv_o);

  assert_capture_valid_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (capture_i && !clear_i && !uncounted_i) |=> ccv_o);

  assert_uncounted_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    uncounted_i |=> !ccv_o);

  assert_ctlwr_keeps_flag_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr_i && !clear_i && !uncounted_i && !capture_i) |=> ccv_o == $past(ccv_o));

  assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !capture_i && !clear_i && !ctl_wr_i) |=> $stable(cc_field_o));

  assert_upper_exp_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_field_o >> (12 + EXP_BITS)) == 16'd0);
endmodule

bind xfer_cycle_encoder xfer_cycle_encoder_chk #(.EXP_BITS(EXP_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .capture_i(capture_i),
  .clear_i(clear_i), .ctl_wr_i(ctl_wr_i), .uncounted_i(uncounted_i),
  .cc_field_o(cc_field_o), .ccv_o(ccv_o)
);

// File: tb/xfer_cycle_encoder_bench.sv
module xfer_cycle_encoder_bench;
  localparam int EB   = 2;
  localparam int MAXC = (1 << (12 + (1 << EB) - 1)) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 0, capture_i = 0, clear_i = 0, ctl_wr_i = 0, uncounted_i = 0;
  logic [15:0] cc_field_o;
  logic        ccv_o;

  int checks = 0, fails = 0;
  int mcnt = 0;
  bit mvld = 0;

  always #5 clk = ~clk;

  xfer_cycle_encoder #(.EXP_BITS(EB)) u_xfer_cycle_encoder (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .capture_i(capture_i),
    .clear_i(clear_i), .ctl_wr_i(ctl_wr_i), .uncounted_i(uncounted_i),
    .cc_field_o(cc_field_o), .ccv_o(ccv_o)
  );

  function automatic logic [15:0] encode(input int v);
    int e, m;
    if (v < 4096) return 16'(v);
    e = 1; m = v;
    while (m >= 8192) begin m = m >> 1; e++; end
    return {4'(e), 12'(m & 12'hFFF)};
  endfunction

  task automatic chk(input string req, input logic [16:0] act, input logic [16:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic check_state(input string req);
    chk(req, {ccv_o, cc_field_o}, {mvld, encode(mcnt)});
  endtask

  task automatic apply(input bit t, input bit cap, input bit clr, input bit wr, input bit unc);
    tick_i = t; capture_i = cap; clear_i = clr; ctl_wr_i = wr; uncounted_i = unc;
    @(posedge clk); @(negedge clk);
    if (clr) begin mcnt = 0; mvld = 0; end
    else begin
      if (wr || cap) mcnt = 0;
      else if (t && mcnt < MAXC) mcnt++;
      if (unc) mvld = 0;
      else if (cap) mvld = 1;
    end
    tick_i = 0; capture_i = 0; clear_i = 0; ctl_wr_i = 0; uncounted_i = 0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) apply(1, 0, 0, 0, 0);
  endtask

  task automatic t_reset;
    chk("R1 reset", {ccv_o, cc_field_o}, 17'd0);
  endtask

  task automatic t_small;
    ticks(100);
    check_state("R2 count 100");
    chk("R3 small value", {1'b0, cc_field_o}, 17'd100);
    for (int i = 0; i < 5; i++) apply(0, 0, 0, 0, 0);
    check_state("R2 hold no tick");
    ticks(3995);
    check_state("R3 count 4095");
  endtask

  task automatic t_capture;
    ticks(7);
    chk("R7 field during capture", {1'b0, cc_field_o}, {1'b0, encode(mcnt)});
    apply(1, 1, 0, 0, 0);
    chk("R7 after capture", {ccv_o, cc_field_o}, {1'b1, 16'd0});
  endtask

  task automatic t_exponent;
    ticks(4096);
    check_state("R4 4096");
    chk("R4 4096 code", {1'b0, cc_field_o}, 17'h1000);
    ticks(5003 - 4096);
    check_state("R4 5003");
    ticks(10001 - 5003);
    check_state("R4 10001");
    ticks(20007 - 10001);
    check_state("R4 20007");
    chk("R5 upper exponent zero", {13'd0, cc_field_o[15:12]} & 17'h0C, 17'd0);
  endtask

  task automatic t_saturate;
    ticks(MAXC - mcnt + 50);
    check_state("R6 saturated");
    chk("R6 max code", {1'b0, cc_field_o}, 17'h3FFF);
  endtask

  task automatic t_ctlwr;
    apply(0, 1, 0, 0, 0);
    ticks(20);
    apply(1, 0, 0, 1, 0);
    chk("R9 ctl write", {ccv_o, cc_field_o}, {1'b1, 16'd0});
  endtask

  task automatic t_uncounted;
    ticks(9);
    apply(1, 0, 0, 0, 1);
    check_state("R10 flag dropped");
    chk("R10 flag low", {16'd0, ccv_o}, 17'd0);
    apply(1, 1, 0, 0, 1);
    chk("R10 beats capture", {ccv_o, cc_field_o}, {1'b0, 16'd0});
    apply(1, 1, 0, 0, 0);
    chk("R7 re-armed", {16'd0, ccv_o}, 17'd1);
  endtask

  task automatic t_clear;
    ticks(30);
    apply(1, 1, 1, 0, 0);
    chk("R8 clear beats capture", {ccv_o, cc_field_o}, 17'd0);
    ticks(4);
    check_state("R8 counts after clear");
  endtask

  initial begin
    #200000000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_small();
    t_capture();
    t_exponent();
    t_saturate();
    t_ctlwr();
    t_uncounted();
    t_clear();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule